// File: doc/BRIEF.md
# Shared Above-Row Buffer Sequencer for Intra Prediction and Deblocking

This block orders every access to the above-row pixel storage of a decoder that works on 16x16 macroblocks. One storage is a single row of unfiltered reconstructed pixels, which intra prediction uses as its top neighbours. The other holds three rows of pixels that have already passed the vertical-edge filter. Deblocking reads both stores, so the decoder needs four above rows where it would otherwise need five. For each macroblock the block walks a fixed schedule of loads and stores. It keeps copies in registers of the pixels that are about to be overwritten. It hands a 4x4 patch of mixed filtered and unfiltered pixels to the filter engine for recovery filtering before deblocking runs. It also keeps the right-hand column context of the last macroblock for use by its right neighbour.

A macroblock begins with a start pulse that carries its index along the row and a flag that marks the last macroblock of the row. The block then drives column and row indices and write strobes toward the intra and filter engines. It collects the pixels they return, and it ends with a one-cycle done pulse. The first macroblock row of a frame has nothing above it, so that row performs no loads and no recovery.

Top module: `lbuf_share_ctrl`

## Requirements
- R1: Reset or a `frame_start` pulse puts the block in first-row mode. In that mode `above_avail` is 0 and `left_valid` is 0. An access in progress is abandoned: `mb_busy` and both read-valid outputs are 0 on the following cycle.
- R2: Each store keeps one pixel per column at address index*16 + column. A load of a column returns the pixel stored at that same column of the previous macroblock row. This holds up to the highest index of the widest frame.
- R3: In first-row mode a macroblock makes no loads and raises no recovery request. It performs 16 intra stores and, after `df_done`, 48 filter-row stores.
- R4: In later rows the work runs strictly in this order: 16 intra loads at ascending column, then 16 intra stores at ascending column, then 48 filtered loads (row 0..2, each at column 0..15), then one `df_brow_valid` cycle, then recovery, then the `df_run` wait, then 48 filtered stores in the same row and column order. Load data appears one cycle after the matching address, with its column or row tag.
- R5: During `df_brow_valid`, `df_brow` carries the 16 unfiltered pixels that were in the single-row store before this macroblock's intra stores overwrote them. Pixel k sits at bits [k*PIX_W +: PIX_W].
- R6: The recovery bundle `rec_px` holds 16 pixels. Slots 0..11 are filtered rows 0..2 at columns 0..3 (slot = row*4 + column). Slots 12..15 are the unfiltered pixels at columns 0..3. `rec_valid` and `rec_px` stay unchanged until `rec_ready`.
- R7: `df_run` begins only after the recovery handshake completes. No filtered store happens before `df_done` is seen during `df_run`.
- R8: When `df_done` is accepted, `df_rcol_in` is captured into `left_px`. `left_valid` becomes 1 unless the macroblock is the last of its row, in which case it becomes 0.
- R9: `mb_done` is a one-cycle pulse in the cycle after the last filtered store. After the macroblock flagged last of a row completes, `above_avail` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame begin pulse; returns to first-row mode |
| mb_start | input | 1 | Begin a macroblock |
| mb_idx | input | IDXW | Macroblock index along the row |
| mb_last | input | 1 | Macroblock is the last of its row |
| mb_busy | output | 1 | Macroblock in progress |
| mb_done | output | 1 | Macroblock finished pulse |
| above_avail | output | 1 | Above rows hold valid data |
| intra_rd_valid | output | 1 | Unfiltered above pixel valid |
| intra_rd_col | output | 4 | Column of that pixel |
| intra_rd_px | output | PIX_W | Unfiltered above pixel |
| intra_wr_en | output | 1 | Intra store strobe |
| intra_wr_col | output | 4 | Column to store |
| intra_wr_px | input | PIX_W | Bottom reconstructed pixel from intra |
| df_rd_valid | output | 1 | Filtered above pixel valid |
| df_rd_row | output | 2 | Filtered row 0..2 |
| df_rd_col | output | 4 | Filtered column |
| df_rd_px | output | PIX_W | Filtered above pixel |
| df_brow_valid | output | 1 | Captured unfiltered row valid |
| df_brow | output | 16*PIX_W | Captured unfiltered row |
| rec_valid | output | 1 | Recovery request |
| rec_px | output | 16*PIX_W | Recovery bundle |
| rec_ready | input | 1 | Recovery accepted and finished |
| df_run | output | 1 | Deblocking may run; waiting for completion |
| df_done | input | 1 | Deblocking complete |
| df_rcol_in | input | 64*PIX_W | Right-column context from the filter |
| df_wr_en | output | 1 | Filtered store strobe |
| df_wr_row | output | 2 | Filtered row to store |
| df_wr_col | output | 4 | Filtered column to store |
| df_wr_px | input | PIX_W | Filtered pixel from the filter |
| left_valid | output | 1 | Left context valid |
| left_px | output | 64*PIX_W | Left context pixels |

## Verification
Rows of three macroblocks and rows of four macroblocks are run back to back. Pixel values come from a different seed on each row, so a load that returns data from the wrong column, the wrong row or a stale frame cannot match. Each run starts with a first row and is followed by later rows. This separates the load-free schedule from the full one and shows whether the data carried across rows survives the overwrite. The recovery and completion handshakes are held back for several cycles to expose any store that fires too early. A frame restart between frames and an abort in the middle of a macroblock show that first-row mode really returns.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_ILD, S_IST, S_DLA, S_DLB, S_REC, S_WDF, S_DSA, S_DONE
   } seq_st_t;
   localparam int MB_DIM   = 16;
   localparam int FROWS    = 3;
   localparam int REC_PIX  = 16;
   localparam int RCOL_PIX = 64;
endpackage

// File: rtl/lbuf_mem.sv
module lbuf_mem #(
   parameter int W     = 8,
   parameter int DEPTH = 64,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/lbuf_seq.sv
module lbuf_seq
   import lbuf_pkg::*;
#(
   parameter int IDXW = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            frame_start,
   input  logic            mb_start,
   input  logic [IDXW-1:0] mb_idx,
   input  logic            mb_last,
   input  logic            rec_ready,
   input  logic            df_done,
   output seq_st_t         st,
   output logic [5:0]      cnt,
   output logic [IDXW-1:0] idx_q,
   output logic            last_q,
   output logic            first_row
);
   localparam logic [5:0] ROW_END = 6'(MB_DIM - 1);
   localparam logic [5:0] BLK_END = 6'(MB_DIM * FROWS - 1);

   always_ff @(posedge clk) begin
      if (rst || frame_start) begin
         st        <= S_IDLE;
         cnt       <= '0;
         first_row <= 1'b1;
         last_q    <= 1'b0;
         idx_q     <= '0;
      end else begin
         case (st)
            S_IDLE: if (mb_start) begin
               idx_q  <= mb_idx;
               last_q <= mb_last;
               cnt    <= '0;
               st     <= first_row ? S_IST : S_ILD;
            end
            S_ILD: begin
               cnt <= (cnt == ROW_END) ? '0 : cnt + 6'd1;
               if (cnt == ROW_END) st <= S_IST;
            end
            S_IST: begin
               cnt <= (cnt == ROW_END) ? '0 : cnt + 6'd1;
               if (cnt == ROW_END) st <= first_row ? S_WDF : S_DLA;
            end
            S_DLA: begin
               cnt <= (cnt == BLK_END) ? '0 : cnt + 6'd1;
               if (cnt == BLK_END) st <= S_DLB;
            end
            S_DLB: st <= S_REC;
            S_REC: if (rec_ready) st <= S_WDF;
            S_WDF: if (df_done) begin
               cnt <= '0;
               st  <= S_DSA;
            end
            S_DSA: begin
               cnt <= (cnt == BLK_END) ? '0 : cnt + 6'd1;
               if (cnt == BLK_END) st <= S_DONE;
            end
            S_DONE: begin
               if (last_q) first_row <= 1'b0;
               st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lbuf_share_ctrl.sv
module lbuf_share_ctrl
   import lbuf_pkg::*;
#(
   parameter int PIX_W   = 8,
   parameter int MAX_MBS = 4,
   localparam int IDXW   = (MAX_MBS > 1) ? $clog2(MAX_MBS) : 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     frame_start,
   input  logic                     mb_start,
   input  logic [IDXW-1:0]          mb_idx,
   input  logic                     mb_last,
   output logic                     mb_busy,
   output logic                     mb_done,
   output logic                     above_avail,
   output logic                     intra_rd_valid,
   output logic [3:0]               intra_rd_col,
   output logic [PIX_W-1:0]         intra_rd_px,
   output logic                     intra_wr_en,
   output logic [3:0]               intra_wr_col,
   input  logic [PIX_W-1:0]         intra_wr_px,
   output logic                     df_rd_valid,
   output logic [1:0]               df_rd_row,
   output logic [3:0]               df_rd_col,
   output logic [PIX_W-1:0]         df_rd_px,
   output logic                     df_brow_valid,
   output logic [16*PIX_W-1:0]      df_brow,
   output logic                     rec_valid,
   output logic [16*PIX_W-1:0]      rec_px,
   input  logic                     rec_ready,
   output logic                     df_run,
   input  logic                     df_done,
   input  logic [64*PIX_W-1:0]      df_rcol_in,
   output logic                     df_wr_en,
   output logic [1:0]               df_wr_row,
   output logic [3:0]               df_wr_col,
   input  logic [PIX_W-1:0]         df_wr_px,
   output logic                     left_valid,
   output logic [64*PIX_W-1:0]      left_px
);
   localparam int LINE  = MAX_MBS * MB_DIM;
   localparam int AW_B  = $clog2(LINE);
   localparam int DEP_A = LINE * FROWS;
   localparam int AW_A  = $clog2(DEP_A);
   localparam int HOLDA = FROWS * 4;

   if (PIX_W < 1 || PIX_W > 16) begin : g_bad_pix
      $error("PIX_W must be 1..16");
   end
   if (MAX_MBS < 1) begin : g_bad_mbs
      $error("MAX_MBS must be at least 1");
   end

   seq_st_t         st;
   logic [5:0]      cnt;
   logic [IDXW-1:0] idx_q;
   logic            last_q, first_row;

   lbuf_seq #(.IDXW(IDXW)) u_seq (
      .clk(clk), .rst(rst), .frame_start(frame_start), .mb_start(mb_start),
      .mb_idx(mb_idx), .mb_last(mb_last), .rec_ready(rec_ready),
      .df_done(df_done), .st(st), .cnt(cnt), .idx_q(idx_q),
      .last_q(last_q), .first_row(first_row)
   );

   logic [AW_B-1:0]  b_addr;
   logic [AW_A-1:0]  a_addr;
   logic [PIX_W-1:0] b_rdata, a_rdata;
   logic             b_we, a_we;

   assign b_addr = AW_B'({idx_q, 4'b0000}) + AW_B'(cnt[3:0]);
   assign a_addr = AW_A'(cnt[5:4]) * AW_A'(LINE) + AW_A'(b_addr);
   assign b_we   = (st == S_IST);
   assign a_we   = (st == S_DSA);

   lbuf_mem #(.W(PIX_W), .DEPTH(LINE)) u_bmem (
      .clk(clk), .we(b_we), .addr(b_addr), .wdata(intra_wr_px), .rdata(b_rdata)
   );
   lbuf_mem #(.W(PIX_W), .DEPTH(DEP_A)) u_amem (
      .clk(clk), .we(a_we), .addr(a_addr), .wdata(df_wr_px), .rdata(a_rdata)
   );

   // strobes and indices toward the engines
   assign mb_busy       = (st != S_IDLE);
   assign mb_done       = (st == S_DONE);
   assign above_avail   = !first_row;
   assign intra_wr_en   = b_we;
   assign intra_wr_col  = cnt[3:0];
   assign df_wr_en      = a_we;
   assign df_wr_row     = cnt[5:4];
   assign df_wr_col     = cnt[3:0];
   assign df_brow_valid = (st == S_DLB);
   assign rec_valid     = (st == S_REC);
   assign df_run        = (st == S_WDF);

   // registered load path, cleared by a frame restart
   always_ff @(posedge clk) begin
      if (rst) begin
         intra_rd_valid <= 1'b0;
         df_rd_valid    <= 1'b0;
      end else begin
         intra_rd_valid <= (st == S_ILD) && !frame_start;
         df_rd_valid    <= (st == S_DLA) && !frame_start;
      end
      intra_rd_col <= cnt[3:0];
      intra_rd_px  <= b_rdata;
      df_rd_row    <= cnt[5:4];
      df_rd_col    <= cnt[3:0];
      df_rd_px     <= a_rdata;
   end

   // copies of above pixels kept before overwrite / for recovery
   logic [PIX_W-1:0] hold_b [MB_DIM];
   logic [PIX_W-1:0] hold_a [HOLDA];

   always_ff @(posedge clk) begin
      if (st == S_ILD) hold_b[cnt[3:0]] <= b_rdata;
      if (st == S_DLA && cnt[3:2] == 2'b00) hold_a[{cnt[5:4], cnt[1:0]}] <= a_rdata;
   end

   for (genvar k = 0; k < MB_DIM; k++) begin : g_brow
      assign df_brow[k*PIX_W +: PIX_W] = hold_b[k];
   end
   for (genvar k = 0; k < REC_PIX; k++) begin : g_rec
      if (k < HOLDA) begin : g_a
         assign rec_px[k*PIX_W +: PIX_W] = hold_a[k];
      end else begin : g_b
         assign rec_px[k*PIX_W +: PIX_W] = hold_b[k-HOLDA];
      end
   end

   // right-column context for the next macroblock
   always_ff @(posedge clk) begin
      if (rst || frame_start) begin
         left_valid <= 1'b0;
      end else if (st == S_WDF && df_done) begin
         left_valid <= !last_q;
      end
      if (st == S_WDF && df_done) left_px <= df_rcol_in;
   end
endmodule

// File: rtl/lbuf_share_chk.sv
module lbuf_share_chk #(
   parameter int PIX_W = 8
) (
   input logic                clk,
   input logic                rst,
   input logic                frame_start,
   input logic                above_avail,
   input logic                left_valid,
   input logic                intra_rd_valid,
   input logic                intra_wr_en,
   input logic                df_rd_valid,
   input logic                df_brow_valid,
   input logic                rec_valid,
   input logic                rec_ready,
   input logic [16*PIX_W-1:0] rec_px,
   input logic                df_run,
   input logic                df_done,
   input logic                df_wr_en,
   input logic                mb_done
);
   p_mode_return_r1: assert property (@(posedge clk)
      (rst || frame_start) |=> (!above_avail && !left_valid));

   p_no_load_first_r3: assert property (@(posedge clk) disable iff (rst)
      !above_avail |-> (!intra_rd_valid && !df_rd_valid && !rec_valid));

   p_one_phase_r4: assert property (@(posedge clk) disable iff (rst)
      $onehot0({intra_wr_en, df_brow_valid, rec_valid, df_run, df_wr_en}));

   p_rec_hold_r6: assert property (@(posedge clk) disable iff (rst || frame_start)
      (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_px)));

   p_store_after_ack_r7: assert property (@(posedge clk) disable iff (rst || frame_start)
      $rose(df_wr_en) |-> $past(df_done));

   p_run_after_rec_r7: assert property (@(posedge clk) disable iff (rst || frame_start)
      (rec_valid && rec_ready) |=> df_run);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      mb_done |=> !mb_done);
endmodule

bind lbuf_share_ctrl lbuf_share_chk #(.PIX_W(PIX_W)) u_chk (
   .clk(clk), .rst(rst), .frame_start(frame_start), .above_avail(above_avail),
   .left_valid(left_valid), .intra_rd_valid(intra_rd_valid), .intra_wr_en(intra_wr_en),
   .df_rd_valid(df_rd_valid), .df_brow_valid(df_brow_valid), .rec_valid(rec_valid),
   .rec_ready(rec_ready), .rec_px(rec_px), .df_run(df_run), .df_done(df_done),
   .df_wr_en(df_wr_en), .mb_done(mb_done)
);

// File: tb/tb_lbuf_share_ctrl.sv
module tb_lbuf_share_ctrl;
   localparam int P    = 8;
   localparam int MMB  = 4;
   localparam int IW   = 2;
   localparam int LINE = MMB * 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic frame_start = 1'b0, mb_start = 1'b0, mb_last = 1'b0;
   logic [IW-1:0] mb_idx = '0;
   logic rec_ready = 1'b0, df_done = 1'b0;
   logic [64*P-1:0] df_rcol_in = '0;
   logic mb_busy, mb_done, above_avail, intra_rd_valid, intra_wr_en;
   logic df_rd_valid, df_brow_valid, rec_valid, df_run, df_wr_en, left_valid;
   logic [3:0] intra_rd_col, intra_wr_col, df_rd_col, df_wr_col;
   logic [1:0] df_rd_row, df_wr_row;
   logic [P-1:0] intra_rd_px, intra_wr_px, df_rd_px, df_wr_px;
   logic [16*P-1:0] df_brow, rec_px;
   logic [64*P-1:0] left_px;

   int cur_seed = 0, cur_idx = 0;
   int n_chk = 0, n_fail = 0;
   bit exp_first = 1'b1, exp_lv = 1'b0;
   logic [64*P-1:0] exp_left = '0;
   logic [P-1:0] refB [LINE];
   logic [P-1:0] refA [3][LINE];

   always #5 clk = ~clk;

   function automatic logic [P-1:0] gen(int seed, int idx, int col, int r);
      return P'(seed * 29 + idx * 16 + col * 7 + r * 53 + 1);
   endfunction

   assign intra_wr_px = gen(cur_seed, cur_idx, int'(intra_wr_col), 3);
   assign df_wr_px    = gen(cur_seed, cur_idx, int'(df_wr_col), int'(df_wr_row));

   lbuf_share_ctrl #(.PIX_W(P), .MAX_MBS(MMB)) dut (.*);

   task automatic chk(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

   task automatic run_mb(int idx, bit last);
      int n_rd = 0, n_ist = 0, n_da = 0, n_brow = 0, n_dw = 0, n_rec = 0;
      int maxph = 0, wr = 0, wd = 0;
      bit done = 1'b0;
      bit first = exp_first;
      logic [P-1:0] oldb [16];
      logic [64*P-1:0] pat;
      for (int c = 0; c < 16; c++) oldb[c] = refB[idx*16+c];
      for (int k = 0; k < 64; k++) pat[k*P +: P] = P'(cur_seed * 3 + idx * 5 + k * 3);
      @(negedge clk);
      chk("R9", "above_avail at start", above_avail, !first);
      mb_idx = IW'(idx); mb_last = last; mb_start = 1'b1; cur_idx = idx;
      @(negedge clk);
      mb_start = 1'b0;
      for (int cyc = 0; cyc < 400 && !done; cyc++) begin
         int ph = 0;
         int lo = 9;
         if (intra_rd_valid) begin
            lo = 1; ph = 1;
            chk("R2", "unfiltered load", intra_rd_px, oldb[intra_rd_col]);
            chk("R4", "intra load column", intra_rd_col, n_rd % 16);
            n_rd++;
         end
         if (intra_wr_en) begin
            if (lo > 2) lo = 2;
            ph = 2;
            chk("R4", "intra store column", intra_wr_col, n_ist % 16);
            refB[idx*16+int'(intra_wr_col)] = intra_wr_px;
            n_ist++;
         end
         if (df_rd_valid) begin
            if (lo > 3) lo = 3;
            ph = 3;
            chk("R4", "filtered load slot", int'(df_rd_row)*16 + int'(df_rd_col), n_da);
            chk("R2", "filtered load", df_rd_px, refA[df_rd_row][idx*16+int'(df_rd_col)]);
            n_da++;
         end
         if (df_brow_valid) begin
            if (lo > 4) lo = 4;
            ph = 4;
            for (int k = 0; k < 16; k++)
               chk("R5", "captured row", df_brow[k*P +: P], oldb[k]);
            n_brow++;
         end
         if (rec_valid) begin
            if (lo > 5) lo = 5;
            ph = 5;
            for (int k = 0; k < 16; k++)
               chk("R6", "recovery slot", rec_px[k*P +: P],
                   (k < 12) ? refA[k/4][idx*16+k%4] : oldb[k-12]);
            n_rec++;
            if (wr < 3) begin wr++; rec_ready = 1'b0; end
            else rec_ready = 1'b1;
         end else rec_ready = 1'b0;
         if (df_run) begin
            if (lo > 6) lo = 6;
            ph = 6;
            if (wd == 0) begin
               chk("R8", "left_valid", left_valid, exp_lv);
               if (exp_lv) chk("R8", "left context", left_px == exp_left, 1);
               chk("R7", "run only after recovery", (!first) ? n_rec : 1, (!first) ? 4 : 1);
            end
            if (wd < 3) begin wd++; df_done = 1'b0; end
            else begin
               df_done = 1'b1; df_rcol_in = pat;
               exp_lv = !last; exp_left = pat;
            end
         end else df_done = 1'b0;
         if (df_wr_en) begin
            if (lo > 7) lo = 7;
            ph = 7;
            chk("R7", "store waits for done", wd, 3);
            chk("R4", "filtered store slot", int'(df_wr_row)*16 + int'(df_wr_col), n_dw);
            refA[df_wr_row][idx*16+int'(df_wr_col)] = df_wr_px;
            n_dw++;
         end
         if (mb_done) begin
            if (lo > 8) lo = 8;
            ph = 8;
            chk("R9", "done after last store", n_dw, 48);
            done = 1'b1;
         end
         if (ph != 0 && lo < maxph) chk("R4", "phase order", lo, maxph);
         if (ph > maxph) maxph = ph;
         @(negedge clk);
      end
      rec_ready = 1'b0; df_done = 1'b0;
      chk("R9", "macroblock completed", done, 1);
      chk("R9", "done lasts one cycle", mb_done, 0);
      if (first) begin
         chk("R3", "first-row loads", n_rd + n_da + n_brow + n_rec, 0);
      end else begin
         chk("R4", "intra loads", n_rd, 16);
         chk("R4", "filtered loads", n_da, 48);
         chk("R4", "captured row cycles", n_brow, 1);
      end
      chk(first ? "R3" : "R4", "intra stores", n_ist, 16);
      chk(first ? "R3" : "R4", "filtered stores", n_dw, 48);
      if (last && done) exp_first = 1'b0;
   endtask

   task automatic run_row(int nmb, int seed);
      cur_seed = seed;
      for (int i = 0; i < nmb; i++) run_mb(i, i == nmb - 1);
      chk("R9", "above_avail after row", above_avail, 1);
      chk("R8", "left context cleared at row end", left_valid, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1", "above_avail after reset", above_avail, 0);
      chk("R1", "left_valid after reset", left_valid, 0);
      chk("R1", "busy after reset", mb_busy, 0);
      chk("R1", "done after reset", mb_done, 0);
   endtask

   task automatic t_frame_restart();
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      exp_first = 1'b1; exp_lv = 1'b0;
      chk("R1", "above_avail after restart", above_avail, 0);
      chk("R1", "left_valid after restart", left_valid, 0);
   endtask

   task automatic t_abort();
      @(negedge clk);
      mb_idx = '0; mb_last = 1'b0; mb_start = 1'b1;
      @(negedge clk);
      mb_start = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1", "loading before abort", intra_rd_valid, 1);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      exp_first = 1'b1; exp_lv = 1'b0;
      chk("R1", "busy after abort", mb_busy, 0);
      chk("R1", "load valid after abort", intra_rd_valid, 0);
      chk("R1", "above_avail after abort", above_avail, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      run_row(3, 1);
      run_row(3, 2);
      run_row(3, 3);
      t_frame_restart();
      run_row(4, 4);
      run_row(4, 5);
      run_row(4, 6);
      t_abort();
      run_row(2, 7);
      run_row(2, 8);
      summary();
      $finish;
   end
endmodule